// File: doc/BRIEF.md
# Interleaved Shared SRAM Arbiter

This block lets one fast static RAM serve two masters: a video fetch path and an 8 MHz CPU. The block clock is the 16 MHz slot clock. Every cycle of it is one slot, and the slots alternate between the two masters. The block derives the CPU clock from the slot phase. It is high during a CPU slot and low during a video slot, so each CPU clock period holds exactly one slot for each master.

In a CPU slot the arbiter drives the address, data and strobe that it captured from the CPU bus at the start of that slot. A read returns its byte on `cpu_rdata` at the end of the slot, so memory cycles never need a wait state. This holds for ROM and expansion space as well, since they share the same path.

Video slots fetch two consecutive bytes per video address. Each byte goes into a staging register. The video controller copies the staged pair into its output latch pair with its own strobe, whenever it likes. During refresh periods the video slots leave the memory idle.

I/O cycles do not touch the memory. Instead they receive a counted wait so that slow peripherals can keep up. All bus strobes are active high.

Top module: `shared_sram_arbiter`

## Requirements
- R1: While `rst` is high, `cpu_clk` is 0. From the first clock edge after reset, `cpu_clk` toggles on every edge. A value of 1 marks a CPU slot and 0 marks a video slot, so the first slot after reset is a CPU slot.
- R2: A memory read (`cpu_mreq` and `cpu_rd` high at the edge that starts a CPU slot) drives `cpu_addr` to `sram_addr` with `sram_ce`=1 and `sram_we`=0 during that slot. The addressed byte appears on `cpu_rdata` at the next edge and holds until the next read.
- R3: A memory write (`cpu_mreq` and `cpu_wr`) is captured at the start of a CPU slot. `sram_we`, `sram_addr` and `sram_wdata` carry the write only during that slot, and `sram_we` is never high in a video slot.
- R4: In each video slot outside refresh, `sram_ce`=1, `sram_we`=0 and `sram_addr` = {`video_addr`, sel}, where `video_addr` is sampled at the slot start. The bit sel is 0 in the first video slot after reset and alternates in every later video slot.
- R5: A byte fetched with sel=0 is staged for `vid_byte0` and one with sel=1 for `vid_byte1`. A clock edge with `vid_strobe` high copies both staged bytes to the outputs. Without a strobe the outputs hold their values, even if `video_addr` changes.
- R6: A video slot whose start edge sees `vid_refresh` high leaves `sram_ce` low and keeps the staged bytes unchanged.
- R7: An I/O cycle (`cpu_iorq` with `cpu_rd` or `cpu_wr`) sampled at a CPU-slot start raises `cpu_wait` at that edge. The wait stays high across IO_WAIT_CLKS falling `cpu_clk` edges and drops on the last of them, which gives 2*IO_WAIT_CLKS-1 fast cycles. A held request gets only one wait.
- R8: `cpu_wait` is never high during a memory cycle, and an I/O cycle never enables the SRAM.
- R9: An I/O cycle first sampled while `vid_refresh` is high gets no wait at all.
- R10: Reset clears `sram_ce`, `sram_we`, `cpu_wait`, `cpu_rdata`, `vid_byte0` and `vid_byte1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz slot clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | AW | CPU address |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | Registered CPU read data |
| cpu_mreq | input | 1 | Memory request |
| cpu_iorq | input | 1 | I/O request |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wait | output | 1 | Wait request to the CPU (I/O only) |
| cpu_clk | output | 1 | 8 MHz CPU clock, high in CPU slots |
| video_addr | input | AW-1 | Video byte-pair address |
| vid_refresh | input | 1 | Refresh period: no fetch, no wait |
| vid_strobe | input | 1 | Video controller latch strobe |
| vid_byte0 | output | DW | Even video byte latch |
| vid_byte1 | output | DW | Odd video byte latch |
| sram_addr | output | AW | SRAM address |
| sram_wdata | output | DW | SRAM write data |
| sram_rdata | input | DW | SRAM read data (asynchronous read) |
| sram_ce | output | 1 | SRAM chip enable |
| sram_we | output | 1 | SRAM write enable |

## Verification
The bench builds the block with AW=8, so the whole memory fits in a 256-byte model that mirrors every write. Video pairs can therefore be compared byte for byte against that reference. It sets IO_WAIT_CLKS=3, which moves the wait length away from the default and checks that the counter scales to 5 fast cycles and still releases on a falling CPU clock edge. A slot monitor checks every cycle that video slots carry only video addresses and that refresh leaves them idle.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    SLOT_VIDEO = 1'b0,
    SLOT_CPU   = 1'b1
  } slot_e;
endpackage

// File: rtl/arb_slot_seq.sv
module arb_slot_seq
  import arb_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output slot_e slot,
  output logic  vsel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= SLOT_VIDEO;
      vsel <= 1'b0;
    end else begin
      slot <= (slot == SLOT_VIDEO) ? SLOT_CPU : SLOT_VIDEO;
      if (slot == SLOT_CPU) vsel <= ~vsel;
    end
  end

  p_slot_alt_r1: assert property (@(posedge clk) disable iff (rst)
    (slot == SLOT_CPU) |=> (slot == SLOT_VIDEO));
  p_slot_alt2_r1: assert property (@(posedge clk) disable iff (rst)
    (slot == SLOT_VIDEO) |=> (slot == SLOT_CPU));
endmodule

// File: rtl/arb_video_latch.sv
module arb_video_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_video_slot,
  input  logic          fetch_en,
  input  logic          fetch_sel,
  input  logic [DW-1:0] fetch_data,
  input  logic          strobe,
  output logic [DW-1:0] byte0,
  output logic [DW-1:0] byte1
);
  logic [DW-1:0] stage [2];

  for (genvar g = 0; g < 2; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[g] <= '0;
      else if (in_video_slot && fetch_en && (fetch_sel == g[0])) stage[g] <= fetch_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte0 <= '0;
      byte1 <= '0;
    end else if (strobe) begin
      byte0 <= stage[0];
      byte1 <= stage[1];
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> ($stable(byte0) && $stable(byte1)));
endmodule

// File: rtl/arb_io_wait.sv
module arb_io_wait #(
  parameter int IO_WAIT_CLKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cpu_slot,
  input  logic io_req,
  input  logic refresh,
  output logic wait_o
);
  localparam int CW = $clog2(IO_WAIT_CLKS + 1);

  logic [CW-1:0] cnt;
  logic          served;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_o <= 1'b0;
      cnt    <= '0;
      served <= 1'b0;
    end else if (!cpu_slot) begin
      if (!io_req) begin
        served <= 1'b0;
      end else if (!wait_o && !served) begin
        if (refresh) begin
          served <= 1'b1;
        end else begin
          wait_o <= 1'b1;
          cnt    <= CW'(IO_WAIT_CLKS);
        end
      end
    end else if (wait_o) begin
      if (cnt == CW'(1)) begin
        wait_o <= 1'b0;
        cnt    <= '0;
        served <= 1'b1;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(IO_WAIT_CLKS));
  p_wait_fall_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(wait_o) |-> $past(cpu_slot));
  p_wait_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(wait_o) |-> (cpu_slot && $past(io_req)));
  p_refresh_nowait_r9: assert property (@(posedge clk) disable iff (rst)
    (!cpu_slot && refresh && !wait_o) |=> !wait_o);
endmodule

// File: rtl/shared_sram_arbiter.sv
module shared_sram_arbiter
  import arb_pkg::*;
#(
  parameter int AW           = 16,
  parameter int DW           = 8,
  parameter int IO_WAIT_CLKS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          cpu_mreq,
  input  logic          cpu_iorq,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  output logic          cpu_wait,
  output logic          cpu_clk,
  input  logic [AW-2:0] video_addr,
  input  logic          vid_refresh,
  input  logic          vid_strobe,
  output logic [DW-1:0] vid_byte0,
  output logic [DW-1:0] vid_byte1,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_wdata,
  input  logic [DW-1:0] sram_rdata,
  output logic          sram_ce,
  output logic          sram_we
);
  slot_e slot;
  logic  vsel;
  logic  cpu_slot;
  logic  io_req;

  assign cpu_slot = (slot == SLOT_CPU);
  assign cpu_clk  = cpu_slot;
  assign io_req   = cpu_iorq && (cpu_rd || cpu_wr);

  arb_slot_seq u_seq (
    .clk  (clk),
    .rst  (rst),
    .slot (slot),
    .vsel (vsel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr  <= '0;
      sram_wdata <= '0;
      sram_ce    <= 1'b0;
      sram_we    <= 1'b0;
      cpu_rdata  <= '0;
    end else if (!cpu_slot) begin
      sram_addr  <= cpu_addr;
      sram_wdata <= cpu_wdata;
      sram_ce    <= cpu_mreq && (cpu_rd || cpu_wr);
      sram_we    <= cpu_mreq && cpu_wr;
    end else begin
      if (sram_ce && !sram_we) cpu_rdata <= sram_rdata;
      sram_addr <= {video_addr, vsel};
      sram_we   <= 1'b0;
      sram_ce   <= !vid_refresh;
    end
  end

  arb_video_latch #(.DW(DW)) u_vid (
    .clk           (clk),
    .rst           (rst),
    .in_video_slot (!cpu_slot),
    .fetch_en      (sram_ce),
    .fetch_sel     (sram_addr[0]),
    .fetch_data    (sram_rdata),
    .strobe        (vid_strobe),
    .byte0         (vid_byte0),
    .byte1         (vid_byte1)
  );

  arb_io_wait #(.IO_WAIT_CLKS(IO_WAIT_CLKS)) u_io (
    .clk      (clk),
    .rst      (rst),
    .cpu_slot (cpu_slot),
    .io_req   (io_req),
    .refresh  (vid_refresh),
    .wait_o   (cpu_wait)
  );

  p_we_cpu_slot_r3: assert property (@(posedge clk) disable iff (rst)
    sram_we |-> cpu_clk);
  p_refresh_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk && vid_refresh) |=> !sram_ce);
  p_video_read_only_r4: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk && !vid_refresh) |=> (sram_ce && !sram_we));
  p_mem_nowait_r8: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk && sram_ce) |-> !cpu_wait);
  p_io_no_sram_r8: assert property (@(posedge clk) disable iff (rst)
    (!cpu_clk && io_req && !cpu_mreq) |=> !sram_ce);
endmodule

// File: tb/shared_sram_arbiter_bench.sv
module shared_sram_arbiter_bench;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int NW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          cpu_mreq = 1'b0, cpu_iorq = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic          cpu_wait, cpu_clk;
  logic [AW-2:0] video_addr = '0;
  logic          vid_refresh = 1'b0, vid_strobe = 1'b0;
  logic [DW-1:0] vid_byte0, vid_byte1;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_wdata, sram_rdata;
  logic          sram_ce, sram_we;

  logic [DW-1:0] mem     [256];
  logic [DW-1:0] ref_mem [256];
  logic [DW-1:0] q_rd  [$];
  logic [15:0]   q_vid [$];

  int nchk = 0, nfail = 0;
  int slot_viol = 0, memwait_viol = 0;
  logic rd_seen = 1'b0, vs_q = 1'b0, started = 1'b0, exp_sel = 1'b0, finished = 1'b0;

  always #2.5 clk = ~clk;

  shared_sram_arbiter #(.AW(AW), .DW(DW), .IO_WAIT_CLKS(NW)) u_shared_sram_arbiter (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_mreq(cpu_mreq), .cpu_iorq(cpu_iorq), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wait(cpu_wait), .cpu_clk(cpu_clk), .video_addr(video_addr),
    .vid_refresh(vid_refresh), .vid_strobe(vid_strobe), .vid_byte0(vid_byte0),
    .vid_byte1(vid_byte1), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
    .sram_rdata(sram_rdata), .sram_ce(sram_ce), .sram_we(sram_we));

  assign sram_rdata = mem[sram_addr];
  always @(posedge clk) if (sram_ce && sram_we) mem[sram_addr] <= sram_wdata;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pops and slot rules
  always @(posedge clk) vs_q <= vid_strobe;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (q_rd.size() == 0) check("R2 unexpected read", 1, 0);
      else check("R2 read data", cpu_rdata, q_rd.pop_front());
    end
    rd_seen <= cpu_clk && sram_ce && !sram_we;
    if (vs_q) begin
      if (q_vid.size() == 0) check("R5 unexpected strobe", 1, 0);
      else check("R5/R6 video pair", {vid_byte1, vid_byte0}, q_vid.pop_front());
    end
    if (rst) begin
      started <= 1'b0;
      exp_sel <= 1'b0;
    end else begin
      if (cpu_clk) started <= 1'b1;
      if (!cpu_clk && started) begin
        if (vid_refresh) begin
          if (sram_ce) slot_viol++;
        end else if (!sram_ce || sram_we || sram_addr !== {video_addr, exp_sel}) slot_viol++;
        exp_sel <= ~exp_sel;
      end
      if (sram_we && !cpu_clk) slot_viol++;
      if (cpu_mreq && cpu_wait) memwait_viol++;
    end
  end

  task automatic to_video_neg();
    @(negedge clk);
    while (cpu_clk) @(negedge clk);
  endtask
  task automatic to_cpu_neg();
    @(negedge clk);
    while (!cpu_clk) @(negedge clk);
  endtask

  task automatic cpu_read(input logic [AW-1:0] a);
    to_video_neg();
    cpu_addr = a; cpu_mreq = 1; cpu_rd = 1;
    q_rd.push_back(ref_mem[a]);
    @(negedge clk);
    check("R2 read addr", sram_addr, a);
    check("R8 read no wait", cpu_wait, 0);
    @(negedge clk);
    cpu_mreq = 0; cpu_rd = 0;
  endtask

  task automatic cpu_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    to_video_neg();
    cpu_addr = a; cpu_wdata = d; cpu_mreq = 1; cpu_wr = 1;
    ref_mem[a] = d;
    @(negedge clk);
    check("R3 we in cpu slot", {sram_we, sram_ce, sram_addr, sram_wdata}, {2'b11, a, d});
    @(negedge clk);
    cpu_mreq = 0; cpu_wr = 0;
    check("R3 we dropped in video slot", sram_we, 0);
  endtask

  task automatic set_video(input logic [AW-2:0] va, input logic refr);
    to_cpu_neg();
    video_addr = va; vid_refresh = refr;
  endtask

  task automatic strobe_pair(input logic [15:0] exp);
    repeat (8) @(negedge clk);
    vid_strobe = 1;
    q_vid.push_back(exp);
    @(negedge clk);
    vid_strobe = 0;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + 11);
      ref_mem[i] = 8'(i * 37 + 11);
    end
    repeat (4) @(negedge clk);
    // R10 / R1 reset state
    check("R10 reset outputs", {sram_ce, sram_we, cpu_wait, cpu_rdata, vid_byte0, vid_byte1}, 0);
    check("R1 cpu_clk low in reset", cpu_clk, 0);
    rst = 0;
    @(negedge clk); check("R1 first slot cpu", cpu_clk, 1);
    @(negedge clk); check("R1 then video", cpu_clk, 0);
    @(negedge clk); check("R1 alternate", cpu_clk, 1);

    // R2 reads with varied addresses
    cpu_read(8'h00); cpu_read(8'hFF); cpu_read(8'h5A); cpu_read(8'hA5);
    // R3 writes then readback
    cpu_write(8'h10, 8'hC3); cpu_write(8'h11, 8'h3C); cpu_write(8'hFE, 8'h00);
    cpu_read(8'h10); cpu_read(8'h11); cpu_read(8'hFE);
    check("R3 sram model holds write", mem[8'h11], 8'h3C);

    // R4/R5 video pairs
    set_video(7'h08, 0);
    strobe_pair({ref_mem[8'h11], ref_mem[8'h10]});
    set_video(7'h7F, 0);
    strobe_pair({ref_mem[8'hFF], ref_mem[8'hFE]});
    // R5 hold without strobe
    set_video(7'h20, 0);
    repeat (8) @(negedge clk);
    check("R5 hold without strobe", {vid_byte1, vid_byte0}, {ref_mem[8'hFF], ref_mem[8'hFE]});
    strobe_pair({ref_mem[8'h41], ref_mem[8'h40]});
    // R6 refresh: staging unchanged
    set_video(7'h33, 1);
    strobe_pair({ref_mem[8'h41], ref_mem[8'h40]});
    set_video(7'h33, 0);
    strobe_pair({ref_mem[8'h67], ref_mem[8'h66]});

    // R7 io wait
    begin
      int first = -1, last = -1, cnt = 0, io_ce = 0;
      to_video_neg();
      cpu_iorq = 1; cpu_rd = 1;
      for (int k = 0; k < 14; k++) begin
        @(negedge clk);
        if (cpu_wait) begin
          cnt++; last = k;
          if (first < 0) first = k;
        end
        if (cpu_clk && sram_ce) io_ce++;
      end
      check("R7 wait rises at slot start", first, 0);
      check("R7 wait length", cnt, 2 * NW - 1);
      check("R7 single wait per request", last, 2 * NW - 2);
      check("R8 io leaves sram idle", io_ce, 0);
      cpu_iorq = 0; cpu_rd = 0;
    end
    // R9 io during refresh
    begin
      int cnt = 0;
      set_video(7'h01, 1);
      to_video_neg();
      cpu_iorq = 1; cpu_wr = 1;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (cpu_wait) cnt++;
      end
      cpu_iorq = 0; cpu_wr = 0;
      @(negedge clk);
      check("R9 no wait in refresh", cnt, 0);
      set_video(7'h01, 0);
    end
    cpu_read(8'h33);
    repeat (4) @(negedge clk);
    check("R4 slot monitor violations", slot_viol, 0);
    check("R8 memory wait violations", memwait_viol, 0);
    check("R2/R5 scoreboard drained", q_rd.size() + q_vid.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule